// File: doc/BRIEF.md
# Bus power-cycle and INIT sequencer

This block owns the three initialization lines of a backplane bus: INIT, AC-low and DC-low. A host issues one command at a time: force a single line to a level, fire an INIT pulse of fixed length, or play a simulated mains failure and recovery. All timing comes from a millisecond tick. The tick is derived from the clock through a prescaler whose length is the parameter `CLK_KHZ`. The three line levels are presented together as one control byte. A busy flag marks a running timed sequence. A one-cycle acknowledge tells the host that its command has been taken, so the host can return its request to the no-request code.

The controller has five states. `S_IDLE` waits for commands. `S_INIT_PULSE` holds INIT for `PULSE_MS` milliseconds. `S_PF_ACLO`, `S_PF_DCLO` and `S_PF_RESTORE` are the three timed gaps of the power cycle, each `GAP_MS` milliseconds long. The transitions are as follows:
- idle to pulse on a pulse command;
- idle or pulse to `S_PF_ACLO` on a power-cycle command;
- `S_PF_ACLO` to `S_PF_DCLO` when the gap expires, asserting DC-low;
- `S_PF_DCLO` to `S_PF_RESTORE` when the gap expires, releasing AC-low;
- `S_PF_RESTORE` to idle when the gap expires, releasing DC-low;
- pulse to idle when the pulse time expires, releasing INIT.

A synchronous reset from any state returns the controller to idle.

Top module: `bus_init_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, all lines are deasserted after that edge, `busy` is 0 and `cmd_ack` is 0.
- R2: `bus_lines` carries INIT on bit 3, AC-low on bit 4 and DC-low on bit 5, with 1 meaning asserted. All other bits are always 0.
- R3: A set command (`cmd_op` = 1) taken while idle selects its line by `cmd_id` equal to 8'h08, 8'h10 or 8'h20. Any nonzero `cmd_val` asserts the selected line and zero releases it. Any other `cmd_id` value leaves all lines unchanged.
- R4: INIT is never asserted while DC-low is asserted. Asserting DC-low clears INIT at the same edge, and a request to set INIT while DC-low is asserted has no effect.
- R5: A pulse command (`cmd_op` = 2) asserts INIT at the accepting edge and releases it exactly `PULSE_MS` milliseconds later, with `busy` high in between.
- R6: A power-cycle command (`cmd_op` = 3) asserts AC-low at the accepting edge. After each following gap of `GAP_MS` milliseconds it asserts DC-low, then releases AC-low, then releases DC-low. `busy` falls at that last step.
- R7: A power-cycle command arriving during an INIT pulse is taken and starts the power cycle at once. The pulse is abandoned and INIT is next cleared when DC-low asserts; it does not return.
- R8: While `busy` is high, pulse, power-cycle and set commands are acknowledged but change neither the lines nor the phase timing.
- R9: A command is taken at a clock edge where `cmd_op` is nonzero and `cmd_ack` is low. `cmd_ack` is then high for exactly one cycle. Code 0 means no request.
- R10: One millisecond equals `CLK_KHZ` clock cycles, counted from the accepting edge of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_op | input | 2 | Request code: 0 none, 1 set line, 2 INIT pulse, 3 power cycle |
| cmd_id | input | 8 | Line selector mask for set commands |
| cmd_val | input | 16 | Level for set commands, nonzero asserts |
| cmd_ack | output | 1 | One-cycle acknowledge of a taken command |
| busy | output | 1 | A timed sequence is running |
| bus_lines | output | 8 | Control byte with the three line levels |

## Verification
The direct-set path is driven with a table of line and level pairs. The table mixes nonzero levels other than 1, selector values that match no line or match two lines, and INIT requests made while DC-low is up, so that a decoder that accepts wrong selectors or ignores the DC-low interlock can be told apart from a correct one. The timed paths are sampled one cycle before and at each expected edge, which separates off-by-one errors in the prescaler or down-counter from a wrong phase order. Overlapping requests are also exercised: a power cycle started during a pulse, and pulse, set and power-cycle requests made during a power cycle. These show whether preemption and ignoring act as required. A reset in the middle of a pulse checks the return to idle.

// File: rtl/bus_init_pkg.sv
`timescale 1ns/1ps
package bus_init_pkg;
    localparam int BIT_INIT = 3;
    localparam int BIT_ACLO = 4;
    localparam int BIT_DCLO = 5;
    localparam logic [7:0] MASK_INIT = 8'h08;
    localparam logic [7:0] MASK_ACLO = 8'h10;
    localparam logic [7:0] MASK_DCLO = 8'h20;
    localparam int NLINES = 3;
    localparam int IX_INIT = 0;
    localparam int IX_ACLO = 1;
    localparam int IX_DCLO = 2;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_SET    = 2'd1,
        OP_PULSE  = 2'd2,
        OP_PCYCLE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_INIT_PULSE = 3'd1,
        S_PF_ACLO    = 3'd2,
        S_PF_DCLO    = 3'd3,
        S_PF_RESTORE = 3'd4
    } seq_state_e;
endpackage

// File: rtl/init_ms_tick.sv
`timescale 1ns/1ps
module init_ms_tick #(
    parameter int TICKS = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    generate
        if (TICKS < 2) begin : g_direct
            logic unused_in;
            assign unused_in = clk ^ rst ^ restart;
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(TICKS);
            localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/init_gap_timer.sv
`timescale 1ns/1ps
module init_gap_timer #(
    parameter int MS_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [MS_W-1:0] load_val,
    input  logic            tick,
    output logic            expire
);
    logic [MS_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (load) begin
            left <= load_val;
        end else if (tick && (left != '0)) begin
            left <= left - 1'b1;
        end
    end

    assign expire = tick && (left == MS_W'(1));
endmodule

// File: rtl/init_line_reg.sv
`timescale 1ns/1ps
module init_line_reg
    import bus_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] wr_en,
    input  logic [NLINES-1:0] wr_val,
    output logic [NLINES-1:0] q
);
    logic [NLINES-1:0] nxt;

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            assign nxt[i] = wr_en[i] ? wr_val[i] : q[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q[IX_INIT] <= nxt[IX_INIT] & ~nxt[IX_DCLO];
            q[IX_ACLO] <= nxt[IX_ACLO];
            q[IX_DCLO] <= nxt[IX_DCLO];
        end
    end
endmodule

// File: rtl/bus_init_sequencer.sv
`timescale 1ns/1ps
module bus_init_sequencer
    import bus_init_pkg::*;
#(
    parameter int CLK_KHZ  = 100000,
    parameter int PULSE_MS = 50,
    parameter int GAP_MS   = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cmd_op,
    input  logic [7:0]  cmd_id,
    input  logic [15:0] cmd_val,
    output logic        cmd_ack,
    output logic        busy,
    output logic [7:0]  bus_lines
);
    localparam int MS_MAX = (PULSE_MS > GAP_MS) ? PULSE_MS : GAP_MS;
    localparam int MS_W   = $clog2(MS_MAX + 1);
    localparam logic [MS_W-1:0] PULSE_LD = MS_W'(PULSE_MS);
    localparam logic [MS_W-1:0] GAP_LD   = MS_W'(GAP_MS);

    seq_state_e        state, state_nxt;
    logic              ack_q;
    logic              accept;
    op_e               op;
    logic [NLINES-1:0] sel;
    logic              set_level;
    logic [NLINES-1:0] wr_en, wr_val;
    logic [NLINES-1:0] lines_q;
    logic              tmr_load, tick, expire;
    logic [MS_W-1:0]   tmr_val;

    assign op        = op_e'(cmd_op);
    assign accept    = (op != OP_NONE) && !ack_q;
    assign set_level = (cmd_val != 16'h0000);
    assign sel[IX_INIT] = (cmd_id == MASK_INIT);
    assign sel[IX_ACLO] = (cmd_id == MASK_ACLO);
    assign sel[IX_DCLO] = (cmd_id == MASK_DCLO);

    init_ms_tick #(.TICKS(CLK_KHZ)) i_tick (
        .clk(clk), .rst(rst), .restart(tmr_load), .tick(tick)
    );

    init_gap_timer #(.MS_W(MS_W)) i_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .tick(tick), .expire(expire)
    );

    init_line_reg i_lines (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_val(wr_val), .q(lines_q)
    );

    // state register and acknowledge
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            ack_q <= 1'b0;
        end else begin
            state <= state_nxt;
            ack_q <= accept;
        end
    end

    // next state, line writes and timer loads
    always_comb begin
        state_nxt = state;
        wr_en     = '0;
        wr_val    = '0;
        tmr_load  = 1'b0;
        tmr_val   = GAP_LD;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_SET: begin
                            wr_en  = sel;
                            wr_val = {NLINES{set_level}};
                        end
                        OP_PULSE: begin
                            wr_en[IX_INIT]  = 1'b1;
                            wr_val[IX_INIT] = 1'b1;
                            tmr_load        = 1'b1;
                            tmr_val         = PULSE_LD;
                            state_nxt       = S_INIT_PULSE;
                        end
                        OP_PCYCLE: begin
                            wr_en[IX_ACLO]  = 1'b1;
                            wr_val[IX_ACLO] = 1'b1;
                            tmr_load        = 1'b1;
                            state_nxt       = S_PF_ACLO;
                        end
                        default: ;
                    endcase
                end
            end
            S_INIT_PULSE: begin
                if (accept && (op == OP_PCYCLE)) begin
                    wr_en[IX_ACLO]  = 1'b1;
                    wr_val[IX_ACLO] = 1'b1;
                    tmr_load        = 1'b1;
                    state_nxt       = S_PF_ACLO;
                end else if (expire) begin
                    wr_en[IX_INIT] = 1'b1;
                    state_nxt      = S_IDLE;
                end
            end
            S_PF_ACLO: begin
                if (expire) begin
                    wr_en[IX_DCLO]  = 1'b1;
                    wr_val[IX_DCLO] = 1'b1;
                    tmr_load        = 1'b1;
                    state_nxt       = S_PF_DCLO;
                end
            end
            S_PF_DCLO: begin
                if (expire) begin
                    wr_en[IX_ACLO] = 1'b1;
                    tmr_load       = 1'b1;
                    state_nxt      = S_PF_RESTORE;
                end
            end
            S_PF_RESTORE: begin
                if (expire) begin
                    wr_en[IX_DCLO] = 1'b1;
                    state_nxt      = S_IDLE;
                end
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_lines           = 8'h00;
        bus_lines[BIT_INIT] = lines_q[IX_INIT];
        bus_lines[BIT_ACLO] = lines_q[IX_ACLO];
        bus_lines[BIT_DCLO] = lines_q[IX_DCLO];
        busy                = (state != S_IDLE);
        cmd_ack             = ack_q;
    end
endmodule

// File: rtl/bus_init_sequencer_chk.sv
`timescale 1ns/1ps
module bus_init_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_ack,
    input logic       busy,
    input logic [7:0] bus_lines
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (bus_lines == 8'h00 && !busy && !cmd_ack));

    p_spare_bits_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_lines & 8'hC7) == 8'h00);

    p_init_off_dclo_r4: assert property (@(posedge clk) disable iff (rst)
        bus_lines[5] |-> !bus_lines[3]);

    p_dclo_after_aclo_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_lines[5]) && busy) |-> bus_lines[4]);

    p_busy_drives_line_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((bus_lines & 8'h38) != 8'h00));

    p_ack_single_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |=> !cmd_ack);
endmodule

bind bus_init_sequencer bus_init_sequencer_chk i_chk (
    .clk(clk), .rst(rst), .cmd_ack(cmd_ack), .busy(busy), .bus_lines(bus_lines)
);

// File: tb/test_bus_init_sequencer.sv
`timescale 1ns/1ps
module test_bus_init_sequencer;
    localparam int K  = 4;
    localparam int PM = 3;
    localparam int GM = 5;
    localparam int PT = PM * K;
    localparam int GT = GM * K;

    // {cmd_id, cmd_val, expected bus_lines}
    localparam logic [31:0] SET_VEC [0:9] = '{
        32'h08_0100_08, 32'h10_0001_18, 32'h01_0001_18, 32'h20_0001_30,
        32'h08_0001_30, 32'h20_0000_10, 32'h08_0001_18, 32'h18_0000_18,
        32'h10_0000_08, 32'h08_0000_00
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_id = 8'h00;
    logic [15:0] cmd_val = 16'h0000;
    logic        cmd_ack, busy;
    logic [7:0]  bus_lines;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_init_sequencer #(.CLK_KHZ(K), .PULSE_MS(PM), .GAP_MS(GM)) i_bus_init_sequencer (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_val(cmd_val),
        .cmd_ack(cmd_ack), .busy(busy), .bus_lines(bus_lines)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] id, input logic [15:0] val);
        @(negedge clk);
        cmd_op = op; cmd_id = id; cmd_val = val;
        @(posedge clk);
        @(negedge clk);
        chk("R9 ack after accept", {7'd0, cmd_ack}, 8'h01);
        cmd_op = 2'd0;
    endtask

    task automatic chk_state(input string tag, input logic [7:0] lines, input logic b);
        chk(tag, bus_lines, lines);
        chk({tag, " busy"}, {7'd0, busy}, {7'd0, b});
    endtask

    initial begin
        wait_edges(3);
        chk_state("R1 reset", 8'h00, 1'b0);
        chk("R1 ack in reset", {7'd0, cmd_ack}, 8'h00);
        rst = 1'b0;
        wait_edges(1);

        // R3 / R4 / R2: direct-set table
        for (int i = 0; i < 10; i++) begin
            issue(2'd1, SET_VEC[i][31:24], SET_VEC[i][23:8]);
            chk_state($sformatf("R3 R4 set vector %0d", i), SET_VEC[i][7:0], 1'b0);
        end

        // R5 / R10 / R9: INIT pulse timing
        issue(2'd2, 8'h00, 16'h0000);
        chk_state("R5 pulse start", 8'h08, 1'b1);
        wait_edges(1);
        chk("R9 ack one cycle", {7'd0, cmd_ack}, 8'h00);
        wait_edges(PT - 2);
        chk_state("R10 pulse last cycle", 8'h08, 1'b1);
        wait_edges(1);
        chk_state("R5 pulse end", 8'h00, 1'b0);

        // R6: full power cycle
        issue(2'd3, 8'h00, 16'h0000);
        chk_state("R6 aclo on", 8'h10, 1'b1);
        wait_edges(GT - 1);
        chk_state("R6 before dclo", 8'h10, 1'b1);
        wait_edges(1);
        chk_state("R6 dclo on", 8'h30, 1'b1);
        wait_edges(GT - 1);
        chk_state("R6 before aclo off", 8'h30, 1'b1);
        wait_edges(1);
        chk_state("R6 aclo off", 8'h20, 1'b1);
        wait_edges(GT - 1);
        chk_state("R6 before dclo off", 8'h20, 1'b1);
        wait_edges(1);
        chk_state("R6 dclo off", 8'h00, 1'b0);

        // R7: power cycle preempts a running pulse
        issue(2'd2, 8'h00, 16'h0000);
        wait_edges(2);
        issue(2'd3, 8'h00, 16'h0000);
        chk_state("R7 preempt start", 8'h18, 1'b1);
        wait_edges(GT - 1);
        chk_state("R7 init held", 8'h18, 1'b1);
        wait_edges(1);
        chk_state("R7 init cleared by dclo", 8'h30, 1'b1);
        wait_edges(2 * GT);
        chk_state("R7 cycle done", 8'h00, 1'b0);
        wait_edges(PT + 3);
        chk_state("R7 pulse not resumed", 8'h00, 1'b0);

        // R8: requests while busy are ignored
        issue(2'd3, 8'h00, 16'h0000);
        wait_edges(2);
        issue(2'd2, 8'h00, 16'h0000);
        chk_state("R8 pulse ignored", 8'h10, 1'b1);
        issue(2'd1, 8'h10, 16'h0000);
        chk_state("R8 set ignored", 8'h10, 1'b1);
        issue(2'd3, 8'h00, 16'h0000);
        wait_edges(GT - 1 - 8);
        chk_state("R8 timing kept before", 8'h10, 1'b1);
        wait_edges(1);
        chk_state("R8 timing kept at edge", 8'h30, 1'b1);
        wait_edges(2 * GT);
        chk_state("R8 cycle done", 8'h00, 1'b0);

        // R1: synchronous reset mid-pulse
        issue(2'd2, 8'h00, 16'h0000);
        rst = 1'b1;
        wait_edges(1);
        chk_state("R1 reset mid pulse", 8'h00, 1'b0);
        chk("R1 ack cleared", {7'd0, cmd_ack}, 8'h00);
        rst = 1'b0;
        wait_edges(PT + 2);
        chk_state("R1 stays idle", 8'h00, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule